// File: doc/BRIEF.md
# Calibrated RTC Seconds Prescaler

This block turns a free-running oscillator clock of roughly 32 kHz into one pulse per second for a real-time clock. The length of a second is set by a programmable calibration word instead of a fixed divider. An integer field gives the number of oscillator ticks per second. A 4-bit fraction, once enabled, lengthens selected seconds by one tick across a repeating 16-second window. This trims the average rate to one sixteenth of a tick.

Software writes the calibration word through a strobe and can read it back at once. The new value only starts to govern timing at the next second boundary, so the second in progress is never shortened or lengthened part-way. An oscillator enable freezes the prescaler without losing its place. The block also exposes the sub-second tick count. The seconds counter, the bus interface and the oscillator trimming all sit outside this block.

Control is a two-state machine:
- **ST_COUNT** counts the integer part of the second.
- **ST_STRETCH** is the one extra tick of a lengthened second.

The transitions, each taken only on a cycle with the oscillator enable high, are:
- **ST_COUNT → ST_COUNT**: an ordinary count step, or a second boundary when no stretch is due.
- **ST_COUNT → ST_STRETCH**: the count reaches the integer value and the current second is due a stretch.
- **ST_STRETCH → ST_COUNT**: always a second boundary.

Top module: `rtc_sec_prescaler`

## Requirements
- R1: After reset the tick count is 0, the seconds pulse is low, and the calibration readback is 0x007FFF (integer 0x7FFF, fraction 0, fraction disabled).
- R2: The calibration word has three fields. Bits 15:0 hold an integer N, bits 19:16 hold a fraction F, and bit 20 enables the fraction. A second that is not stretched lasts exactly N+1 enabled oscillator ticks.
- R3: The seconds pulse is high in the cycle after the tick that completes a second, and the tick count is 0 in that cycle. Within a second, the tick count rises by one for each enabled tick.
- R4: A 4-bit phase starts at 0 on reset and advances at every second boundary. With bit 20 set, a second whose phase is below F lasts N+2 ticks. Any 16 consecutive seconds under one setting therefore total 16(N+1)+F ticks.
- R5: With bit 20 clear, the fraction field has no effect: every second lasts N+1 ticks.
- R6: The calibration readback shows a written word, unchanged, in the cycle after its write strobe.
- R7: A calibration write takes effect at the next second boundary. The second in progress keeps its old length, and this holds even when the write coincides with a boundary.
- R8: While the oscillator enable is low, the tick count holds, no seconds pulse appears, and those cycles do not count toward the second.
- R9: With the reset calibration, the first second lasts 32768 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | Oscillator enable; low freezes the prescaler |
| cal_wr | input | 1 | Calibration write strobe |
| cal_wdata | input | 21 | Calibration word: [20] fraction enable, [19:16] fraction, [15:0] integer |
| sec_pulse | output | 1 | Seconds pulse |
| tick_count | output | 16 | Current sub-second tick count |
| cal_rdata | output | 21 | Calibration readback |

## Verification
The bench sweeps integer values of 0, 1 and 3. For each one it tries every fraction with the enable set, and one fraction with the enable clear. It predicts each second's length from its own phase count and checks both the single seconds and the 16-second totals:
- A design that stretched the wrong phases, or was off by one in the phase compare, would show the wrong pattern of long seconds.
- A design that let a disabled fraction through would lengthen seconds it should leave alone.
- An integer value of 0 exercises a write that lands on a boundary cycle. A design that dropped the forwarding there would apply the new value one second late.
- A mid-second stall checks that disabled cycles neither advance the count nor trigger a pulse. A design that ignored the enable would deliver the second early.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;
    localparam int TICK_W  = 16;
    localparam int FRAC_W  = 4;
    localparam int CAL_W   = TICK_W + FRAC_W + 1;
    localparam int PHASE_N = 1 << FRAC_W;

    typedef struct packed {
        logic              frac_en;
        logic [FRAC_W-1:0] frac;
        logic [TICK_W-1:0] whole;
    } cal_word_t;

    typedef enum logic [0:0] {
        ST_COUNT   = 1'b0,
        ST_STRETCH = 1'b1
    } presc_state_e;

    localparam cal_word_t CAL_DEFAULT = '{frac_en: 1'b0, frac: '0, whole: 16'h7FFF};
endpackage

// File: rtl/rtc_cal_store.sv
module rtc_cal_store
    import rtc_presc_pkg::*;
#(
    parameter cal_word_t CAL_RESET = CAL_DEFAULT
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  cal_word_t wdata,
    input  logic      boundary,
    output cal_word_t written,
    output cal_word_t active
);
    // Written copy follows the strobe at once; the active copy only moves on a
    // second boundary, taking a same-cycle write directly.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written <= CAL_RESET;
            active  <= CAL_RESET;
        end else begin
            if (wr)
                written <= wdata;
            if (boundary)
                active <= wr ? wdata : written;
        end
    end
endmodule

// File: rtl/rtc_frac_phase.sv
module rtc_frac_phase
    import rtc_presc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      boundary,
    input  cal_word_t active,
    output logic      stretch
);
    logic [FRAC_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (boundary)
            phase <= phase + 1'b1;
    end

    assign stretch = active.frac_en && (phase < active.frac);
endmodule

// File: rtl/rtc_tick_fsm.sv
module rtc_tick_fsm
    import rtc_presc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic [TICK_W-1:0] whole,
    input  logic              stretch,
    output logic              boundary,
    output logic [TICK_W-1:0] tick_count,
    output logic              sec_pulse
);
    presc_state_e      state, nxt_state;
    logic [TICK_W-1:0] nxt_count;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_COUNT;
            tick_count <= '0;
            sec_pulse  <= 1'b0;
        end else begin
            state      <= nxt_state;
            tick_count <= nxt_count;
            sec_pulse  <= boundary;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt_state = state;
        nxt_count = tick_count;
        boundary  = 1'b0;
        if (osc_en) begin
            unique case (state)
                ST_COUNT: begin
                    if (tick_count == whole) begin
                        if (stretch) begin
                            nxt_state = ST_STRETCH;
                            nxt_count = tick_count + 1'b1;
                        end else begin
                            boundary = 1'b1;
                        end
                    end else begin
                        nxt_count = tick_count + 1'b1;
                    end
                end
                ST_STRETCH: boundary = 1'b1;
                default:    boundary = 1'b1;
            endcase
        end
        if (boundary) begin
            nxt_state = ST_COUNT;
            nxt_count = '0;
        end
    end
endmodule

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler
    import rtc_presc_pkg::*;
#(
    parameter cal_word_t CAL_RESET = CAL_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              cal_wr,
    input  logic [CAL_W-1:0]  cal_wdata,
    output logic              sec_pulse,
    output logic [TICK_W-1:0] tick_count,
    output logic [CAL_W-1:0]  cal_rdata
);
    cal_word_t cal_written, cal_active;
    logic      boundary, stretch;

    rtc_cal_store #(.CAL_RESET(CAL_RESET)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cal_wr),
        .wdata    (cal_word_t'(cal_wdata)),
        .boundary (boundary),
        .written  (cal_written),
        .active   (cal_active)
    );

    rtc_frac_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .active   (cal_active),
        .stretch  (stretch)
    );

    rtc_tick_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_en     (osc_en),
        .whole      (cal_active.whole),
        .stretch    (stretch),
        .boundary   (boundary),
        .tick_count (tick_count),
        .sec_pulse  (sec_pulse)
    );

    assign cal_rdata = cal_written;
endmodule

// File: rtl/rtc_presc_checker.sv
module rtc_presc_checker
    import rtc_presc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              osc_en,
    input logic              cal_wr,
    input logic [CAL_W-1:0]  cal_wdata,
    input logic              sec_pulse,
    input logic [TICK_W-1:0] tick_count,
    input logic [CAL_W-1:0]  cal_rdata
);
    AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> $past(osc_en)); // R8

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> ($stable(tick_count) && !sec_pulse)); // R8

    AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (tick_count == '0)); // R3

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osc_en) && !sec_pulse) |-> (tick_count == TICK_W'($past(tick_count) + 1'b1))); // R3

    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cal_wr |=> (cal_rdata == $past(cal_wdata))); // R6
endmodule

bind rtc_sec_prescaler rtc_presc_checker u_presc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .cal_wr     (cal_wr),
    .cal_wdata  (cal_wdata),
    .sec_pulse  (sec_pulse),
    .tick_count (tick_count),
    .cal_rdata  (cal_rdata)
);

// File: tb/test_rtc_sec_prescaler.sv
`timescale 1ns/1ps
module test_rtc_sec_prescaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en = 1'b0;
    logic        cal_wr = 1'b0;
    logic [20:0] cal_wdata = '0;
    logic        sec_pulse;
    logic [15:0] tick_count;
    logic [20:0] cal_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the calibration: {en, frac, whole}
    int  cur_whole = 32'h7FFF, cur_frac = 0; bit cur_en = 0;
    int  pend_whole = 32'h7FFF, pend_frac = 0; bit pend_en = 0;
    int  pulses = 0;
    bit  rb_pending = 0;
    logic [20:0] rb_val;

    rtc_sec_prescaler i_rtc_sec_prescaler (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cal_wr(cal_wr),
        .cal_wdata(cal_wdata), .sec_pulse(sec_pulse),
        .tick_count(tick_count), .cal_rdata(cal_rdata)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic write_cal(input int w, input int f, input bit en);
        cal_wdata  = {en, 4'(f), 16'(w)};
        cal_wr     = 1'b1;
        pend_whole = w; pend_frac = f; pend_en = en;
        rb_val     = {en, 4'(f), 16'(w)};
        rb_pending = 1;
    endtask

    // Called at a negedge; counts enabled edges until the next pulse is seen.
    task automatic next_period(input int start, output int n, output bit tc_bad);
        n = start; tc_bad = 0;
        do begin
            if (osc_en) n++;
            @(negedge clk);
            cal_wr = 1'b0;
            if (rb_pending) begin
                rb_pending = 0;
                chk(cal_rdata == rb_val, "R6", "readback", cal_rdata, rb_val);
            end
            if (sec_pulse && tick_count != 16'd0) tc_bad = 1;
            if (!sec_pulse && tick_count != 16'(n)) tc_bad = 1;
        end while (!sec_pulse);
    endtask

    task automatic one_second(input string tag, output int n);
        int  exp;
        bit  bad;
        exp = cur_whole + 1 + ((cur_en && (pulses % 16) < cur_frac) ? 1 : 0);
        next_period(0, n, bad);
        chk(n == exp, tag, "second length", n, exp);
        chk(!bad, "R3", "tick count sequence", bad, 0);
        cur_whole = pend_whole; cur_frac = pend_frac; cur_en = pend_en;
        pulses++;
    endtask

    task automatic run_seconds(input int w, input int f, input bit en);
        int n, sum, exp;
        sum = 0;
        write_cal(w, f, en);
        one_second("R7", n);
        for (int i = 0; i < 16; i++) begin
            one_second(en ? "R4" : "R2", n);
            sum += n;
        end
        exp = 16 * (w + 1) + (en ? f : 0);
        chk(sum == exp, en ? "R4" : "R5", "16-second total", sum, exp);
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int  n;
        bit  bad;
        int  wl[3] = '{0, 1, 3};
        logic [15:0] held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tick_count == 0, "R1", "reset tick count", tick_count, 0);
        chk(sec_pulse == 0, "R1", "reset pulse", sec_pulse, 0);
        chk(cal_rdata == 21'h007FFF, "R1", "reset readback", cal_rdata, 21'h007FFF);
        repeat (3) @(negedge clk);
        chk(tick_count == 0 && !sec_pulse, "R8", "idle while disabled", tick_count, 0);

        // first second uses reset calibration even though a write lands now
        osc_en = 1'b1;
        write_cal(3, 0, 0);
        one_second("R9", n);
        chk(n == 32768, "R9", "default second", n, 32768);

        for (int wi = 0; wi < 3; wi++) begin
            run_seconds(wl[wi], 9, 0);
            for (int f = 0; f < 16; f++)
                run_seconds(wl[wi], f, 1);
        end

        // stall mid-second
        write_cal(5, 0, 0);
        one_second("R7", n);
        one_second("R2", n);
        @(negedge clk); @(negedge clk);
        chk(tick_count == 2, "R3", "count after two ticks", tick_count, 2);
        held = tick_count;
        osc_en = 1'b0;
        bad = 0;
        repeat (7) begin
            @(negedge clk);
            if (sec_pulse || tick_count != held) bad = 1;
        end
        chk(!bad, "R8", "hold while disabled", tick_count, held);
        osc_en = 1'b1;
        next_period(2, n, bad);
        chk(n == 6, "R8", "stalled second length", n, 6);
        chk(!bad, "R3", "count after stall", bad, 0);
        finish_run();
    end
endmodule